// File: doc/BRIEF.md
# Three-Client Rotating Token Bus Arbiter

This block decides which of three clients may use a shared bus. A central pointer selects one client at a time. Each client has its own small controller. When the pointer rests on a controller whose client is requesting, that controller takes the bus and raises the client's acknowledge. It keeps the acknowledge until the client lets its request fall. When the selected controller is idle, or has just finished a transfer, it raises a one-cycle pass strobe. The pointer moves only on a clock where some pass strobe is high.

A client raises its request and holds it until it sees its acknowledge. It may keep the request high for a limited, variable number of further cycles to finish its transfer, and then drops it. Grants move round the clients in a fixed ring. While nobody requests, the pointer keeps stepping, spending two cycles at each client. This bounds how long any client can wait.

Top module: `token_arbiter`

## Requirements
- R1: While reset is high and on the first cycle after it, every acknowledge is low and the pointer selects client 0.
- R2: At most one bit of `ack` is high in any cycle.
- R3: On every clock where some controller's pass strobe is high, the pointer moves one step in the ring 0, 1, 2, 0.
- R4: On a clock with no pass strobe high, the pointer keeps its value. While a client holds the bus, no other client is granted.
- R5: An idle controller that is selected while its request is high raises its acknowledge on the next clock edge. A controller that is not selected never raises its acknowledge, even when its request is high.
- R6: An idle controller that is selected while its request is low raises its pass strobe on the next edge instead of granting.
- R7: An acknowledge stays high on every edge where its request is still high.
- R8: When a request is low while its acknowledge is high, the acknowledge drops on the next edge and that controller's pass strobe rises on the same edge.
- R9: A pass strobe lasts exactly one cycle. The next grant comes no earlier than the cycle after the pointer has moved.
- R10: Suppose every client drops its request at most H cycles after it sees its acknowledge. Then a request is acknowledged within 3*(H+4) cycles of being raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NUM_CLIENTS | Request per client; bit i belongs to client i |
| ack | output | NUM_CLIENTS | Acknowledge per client; bit i high while client i owns the bus |

## Verification
The properties assume that clients follow the protocol: a request, once raised, stays high until its acknowledge appears, and the hold after the acknowledge is finite. The bounded-wait requirement also depends on how long each client holds. The stimulus drives each client as a small process that raises its request only after a random gap. It never lowers a request before the grant, and it releases within a random hold drawn from 0 to H cycles. So every run stays inside those assumptions while it mixes idle stretches, contention from all three clients, and back-to-back requests.

// File: rtl/token_arb_pkg.sv
package token_arb_pkg;

  typedef enum logic [1:0] {
    CtlIdle    = 2'd0,
    CtlOwn     = 2'd1,
    CtlHandoff = 2'd2
  } ctlState_t;

  typedef struct packed {
    logic advance;
  } selStrobe_t;

endpackage

// File: rtl/arb_client_ctl.sv
module arb_client_ctl
  import token_arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic selected,
  input  logic req,
  output logic ack,
  output logic pass
);

  ctlState_t state;
  ctlState_t stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      CtlIdle:    if (selected) stateNext = req ? CtlOwn : CtlHandoff;
      CtlOwn:     if (!req) stateNext = CtlHandoff;
      CtlHandoff: stateNext = CtlIdle;
      default:    stateNext = CtlIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= CtlIdle;
    else     state <= stateNext;
  end

  assign ack  = (state == CtlOwn);
  assign pass = (state == CtlHandoff);

endmodule

// File: rtl/arb_control.sv
module arb_control
  import token_arb_pkg::*;
#(
  parameter int NUM_CLIENTS = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_CLIENTS-1:0] selOneHot,
  input  logic [NUM_CLIENTS-1:0] req,
  output logic [NUM_CLIENTS-1:0] ack,
  output logic [NUM_CLIENTS-1:0] passVec,
  output selStrobe_t             strobe
);

  for (genvar g = 0; g < NUM_CLIENTS; g++) begin : gClient
    arb_client_ctl u_ctl (
      .clk      (clk),
      .rst      (rst),
      .selected (selOneHot[g]),
      .req      (req[g]),
      .ack      (ack[g]),
      .pass     (passVec[g])
    );
  end

  assign strobe.advance = |passVec;

endmodule

// File: rtl/arb_selector.sv
module arb_selector
  import token_arb_pkg::*;
#(
  parameter int NUM_CLIENTS = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  selStrobe_t             strobe,
  output logic [NUM_CLIENTS-1:0] selOneHot
);

  localparam int IDX_W = (NUM_CLIENTS > 1) ? $clog2(NUM_CLIENTS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CLIENTS - 1);

  logic [IDX_W-1:0] selIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      selIdx <= '0;
    end else if (strobe.advance) begin
      selIdx <= (selIdx == LAST_IDX) ? '0 : selIdx + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_CLIENTS; g++) begin : gDecode
    assign selOneHot[g] = (selIdx == IDX_W'(g));
  end

endmodule

// File: rtl/token_arbiter.sv
module token_arbiter
  import token_arb_pkg::*;
#(
  parameter int NUM_CLIENTS = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_CLIENTS-1:0] req,
  output logic [NUM_CLIENTS-1:0] ack
);

  logic [NUM_CLIENTS-1:0] selOneHot;
  logic [NUM_CLIENTS-1:0] passVec;
  selStrobe_t             strobe;

  arb_control #(.NUM_CLIENTS(NUM_CLIENTS)) u_control (
    .clk       (clk),
    .rst       (rst),
    .selOneHot (selOneHot),
    .req       (req),
    .ack       (ack),
    .passVec   (passVec),
    .strobe    (strobe)
  );

  arb_selector #(.NUM_CLIENTS(NUM_CLIENTS)) u_selector (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .selOneHot (selOneHot)
  );

endmodule

// File: rtl/token_arbiter_chk.sv
module token_arbiter_chk #(
  parameter int NUM_CLIENTS = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_CLIENTS-1:0] req,
  input logic [NUM_CLIENTS-1:0] ack,
  input logic [NUM_CLIENTS-1:0] selOneHot,
  input logic [NUM_CLIENTS-1:0] passVec
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (ack == '0) && (selOneHot == NUM_CLIENTS'(1))); // R1

  AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack)); // R2

  AST_SEL_ROTATE: assert property (@(posedge clk) disable iff (rst)
    (|passVec) |=> selOneHot == {$past(selOneHot[NUM_CLIENTS-2:0]), $past(selOneHot[NUM_CLIENTS-1])}); // R3

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(|passVec) |=> $stable(selOneHot)); // R4

  for (genvar g = 0; g < NUM_CLIENTS; g++) begin : gPerClient
    AST_GRANT_SELECTED: assert property (@(posedge clk) disable iff (rst)
      $rose(ack[g]) |-> $past(selOneHot[g] && req[g])); // R5

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
      (selOneHot[g] && !ack[g] && !passVec[g] && !req[g]) |=> passVec[g]); // R6

    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
      (ack[g] && req[g]) |=> ack[g]); // R7

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
      (ack[g] && !req[g]) |=> (!ack[g] && passVec[g])); // R8

    AST_PASS_SINGLE: assert property (@(posedge clk) disable iff (rst)
      passVec[g] |=> (!passVec[g] && !ack[g])); // R9
  end

endmodule

bind token_arbiter token_arbiter_chk #(.NUM_CLIENTS(NUM_CLIENTS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .ack       (ack),
  .selOneHot (selOneHot),
  .passVec   (passVec)
);

// File: tb/token_arbiter_bench.sv
`timescale 1ns/1ps
module token_arbiter_bench;

  localparam int N        = 3;
  localparam int HOLD_MAX = 6;
  localparam int BOUND    = 3 * (HOLD_MAX + 4);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic [N-1:0] ack;

  int checks = 0;
  int errors = 0;

  // behavioural reference: phase 0 idle, 1 owning, 2 handing off
  int ph[N];
  int ptr;

  // random client processes
  int gap[N];
  int hold[N];
  int waitCnt[N];
  bit granted[N];

  always #2.5 clk = ~clk;

  token_arbiter #(.NUM_CLIENTS(N)) u_token_arbiter (
    .clk (clk),
    .rst (rst),
    .req (req),
    .ack (ack)
  );

  function automatic logic [N-1:0] modelAck();
    logic [N-1:0] a = '0;
    for (int i = 0; i < N; i++) a[i] = (ph[i] == 1);
    return a;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < N; i++) ph[i] = 0;
    ptr = 0;
  endtask

  task automatic modelStep(input logic [N-1:0] r);
    int  nx[N];
    bit  anyPass = 0;
    for (int i = 0; i < N; i++) begin
      if (ph[i] == 2) anyPass = 1;
      case (ph[i])
        0:       nx[i] = (ptr == i) ? (r[i] ? 1 : 2) : 0;
        1:       nx[i] = r[i] ? 1 : 2;
        default: nx[i] = 0;
      endcase
    end
    for (int i = 0; i < N; i++) ph[i] = nx[i];
    if (anyPass) ptr = (ptr + 1) % N;
  endtask

  // one clock: model follows the edge, outputs compared at the next falling edge
  task automatic cycle();
    modelStep(req);
    @(negedge clk);
    check($countones(ack) <= 1, "R2 mutual exclusion", ack, modelAck());
    check(ack === modelAck(), "R3 R4 R5 R6 R7 R8 R9 model compare", ack, modelAck());
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog (R10): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    check(ack === '0, "R1 acks low in reset", ack, '0);
    rst = 1'b0;

    // all three request: client 0 first because pointer starts there
    req = 3'b111;
    cycle();
    check(ack === 3'b001, "R1 R5 first grant to client 0", ack, 3'b001);
    repeat (3) begin
      cycle();
      check(ack === 3'b001, "R4 R7 holder keeps bus", ack, 3'b001);
    end
    req[0] = 1'b0;
    cycle();
    check(ack === 3'b000, "R8 release on request drop", ack, 3'b000);
    cycle();
    check(ack === 3'b000, "R9 no grant during pass", ack, 3'b000);
    cycle();
    check(ack === 3'b010, "R3 next in ring is client 1", ack, 3'b010);
    req[1] = 1'b0;
    cycle();
    cycle();
    cycle();
    check(ack === 3'b100, "R3 ring moves to client 2", ack, 3'b100);
    req = '0;
    cycle();
    cycle();
    cycle();  // pointer back at 0, controller 0 idle and unrequested: hands off
    req[1] = 1'b1;
    cycle();
    check(ack === 3'b000, "R5 unselected client not granted", ack, 3'b000);
    cycle();
    check(ack === 3'b010, "R6 idle client passes on", ack, 3'b010);
    req = '0;
    repeat (4) cycle();

    // random traffic with bounded holds
    for (int i = 0; i < N; i++) begin
      gap[i] = $urandom_range(4, 0);
      hold[i] = 0;
      waitCnt[i] = 0;
      granted[i] = 0;
    end
    repeat (4000) begin
      for (int i = 0; i < N; i++) begin
        if (!req[i]) begin
          if (gap[i] == 0) begin
            req[i] = 1'b1;
            waitCnt[i] = 0;
            granted[i] = 0;
          end else begin
            gap[i]--;
          end
        end else if (!ack[i] && !granted[i]) begin
          waitCnt[i]++;
          if (waitCnt[i] == BOUND + 1)
            check(0, "R10 wait exceeds bound", N'(waitCnt[i]), N'(BOUND));
        end else begin
          if (!granted[i]) begin
            granted[i] = 1;
            check(waitCnt[i] <= BOUND, "R10 wait within bound", N'(waitCnt[i]), N'(BOUND));
            hold[i] = $urandom_range(HOLD_MAX, 0);
          end
          if (hold[i] == 0) begin
            req[i] = 1'b0;
            gap[i] = $urandom_range(4, 0);
          end else begin
            hold[i]--;
          end
        end
      end
      cycle();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule